// File: doc/BRIEF.md
# Masked Chip-Select Address Decoder

This block maps each internal bus access onto one of six programmable chip-select windows. A window matches when the upper 16 bits of the access address equal its base tag. Mask bits set to 1 are excluded from that compare. Each window also carries an enable flag and a write-lock flag. For every request the block gives one registered outcome: a one-hot select naming the winning window, a miss error, or a write-lock error that starts no external cycle.

Configuration arrives on a single-cycle register write port. Each window uses a 12-byte stride: its tag at offset 0, its mask word at offset 4 and a timing control word at offset 8. The timing control word belongs to the external bus sequencer, so the decoder ignores it.

Out of reset, window 0 is a catch-all select. Every access selects window 0 until window 0's own enable flag is written to 1. After that, all windows decode as programmed.

Top module: `cs_window_decoder`

## Requirements
- R1: After synchronous reset every window has tag, mask, enable and write-lock equal to zero, and `cs_sel`, `nohit_err` and `wp_err` are all low.
- R2: A window's tag is compared with `req_addr[31:16]`. A mask bit of 1 excludes that address bit from the compare, and a mask bit of 0 requires equality.
- R3: `cs_sel` is one-hot or zero. When several enabled windows match, the lowest-numbered window is selected (bit n of `cs_sel` is window n).
- R4: A window other than window 0 never matches while its enable flag is 0.
- R5: While window 0's enable flag is 0, every request (read or write) selects window 0 only (`cs_sel` = 6'b000001). Other windows and all write-lock flags are disregarded.
- R6: A write whose winning window has its write-lock flag set produces `wp_err` = 1 and `cs_sel` = 0. A read of the same window selects it normally. Write-lock flags of non-winning windows have no effect.
- R7: With window 0 enabled, a request that matches no enabled window produces `nohit_err` = 1 and `cs_sel` = 0.
- R8: Outputs are registered. A request sampled at a rising edge shows its outcome after that edge for exactly one cycle. A cycle without a request leaves all three outputs low.
- R9: Register map (byte offsets, n = window index 0..5):
  - 12n+0 is the tag register, with the tag in bits 31:16.
  - 12n+4 is the mask register, with the enable flag in bit 0, the write-lock flag in bit 8 and the mask in bits 31:16.
  - 12n+8 holds a timing word that does not affect decoding.
  - Writes to any other offset change nothing.
- R10: A configuration write and a request in the same cycle: the request is decoded with the configuration as it was before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 7 | Configuration byte offset |
| cfg_wdata | input | 32 | Configuration write data |
| req_valid | input | 1 | Access request strobe |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_addr | input | 32 | Access address |
| cs_sel | output | 6 | Registered one-hot window select |
| nohit_err | output | 1 | Registered miss error pulse |
| wp_err | output | 1 | Registered write-lock error pulse |

## Verification
A configuration write and a decode can fall in the same cycle. The question is whether a request sees the window contents from before or after that write. The bench provokes this directly: it retargets a window's tag while a request addresses the old tag. It then reads both the old and the new tag in the following cycles. Randomly interleaved configuration writes and requests repeat the collision many times. Every outcome is judged against a bench model that applies each write only after decoding the request of the same cycle.

// File: rtl/cs_dec_pkg.sv
package cs_dec_pkg;
  // register map layout: window stride and field offsets within a window
  localparam int unsigned WIN_STRIDE = 12;
  localparam int unsigned OFS_TAG    = 0;
  localparam int unsigned OFS_MASK   = 4;
  localparam int unsigned OFS_TIMING = 8;
  // bit positions within the mask register
  localparam int unsigned EN_BIT     = 0;
  localparam int unsigned LOCK_BIT   = 8;
endpackage

// File: rtl/cs_cfg_regs.sv
module cs_cfg_regs
  import cs_dec_pkg::*;
#(
  parameter int unsigned NUM_WIN = 6,
  parameter int unsigned TAG_W   = 16,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned CFG_AW  = 7
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            cfg_we,
  input  logic [CFG_AW-1:0]               cfg_addr,
  input  logic [DATA_W-1:0]               cfg_wdata,
  output logic [NUM_WIN-1:0][TAG_W-1:0]   win_tag,
  output logic [NUM_WIN-1:0][TAG_W-1:0]   win_mask,
  output logic [NUM_WIN-1:0]              win_en,
  output logic [NUM_WIN-1:0]              win_lock
);
  localparam int unsigned TAG_LSB = DATA_W - TAG_W;

  // The timing word at OFS_TIMING is owned by the bus sequencer; not stored here.
  always_ff @(posedge clk) begin
    if (rst) begin
      win_tag  <= '0;
      win_mask <= '0;
      win_en   <= '0;
      win_lock <= '0;
    end else if (cfg_we) begin
      for (int w = 0; w < NUM_WIN; w++) begin
        if (cfg_addr == CFG_AW'(w * WIN_STRIDE + OFS_TAG)) begin
          win_tag[w] <= cfg_wdata[TAG_LSB +: TAG_W];
        end
        if (cfg_addr == CFG_AW'(w * WIN_STRIDE + OFS_MASK)) begin
          win_mask[w] <= cfg_wdata[TAG_LSB +: TAG_W];
          win_en[w]   <= cfg_wdata[EN_BIT];
          win_lock[w] <= cfg_wdata[LOCK_BIT];
        end
      end
    end
  end
endmodule

// File: rtl/cs_window_match.sv
module cs_window_match #(
  parameter int unsigned TAG_W = 16
) (
  input  logic [TAG_W-1:0] addr_tag,
  input  logic [TAG_W-1:0] tag,
  input  logic [TAG_W-1:0] dont_care,
  input  logic             enable,
  output logic             hit
);
  logic [TAG_W-1:0] diff;

  always_comb begin
    diff = (addr_tag ^ tag) & ~dont_care;
    hit  = enable && (diff == '0);
  end
endmodule

// File: rtl/cs_select_arb.sv
module cs_select_arb #(
  parameter int unsigned NUM_WIN = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic               catch_all,
  input  logic [NUM_WIN-1:0] hit,
  input  logic [NUM_WIN-1:0] lock,
  output logic [NUM_WIN-1:0] sel_q,
  output logic               miss_q,
  output logic               lock_err_q
);
  logic [NUM_WIN-1:0] winner;
  logic               found;
  logic               winner_locked;

  // lowest-numbered matching window takes the select
  always_comb begin
    winner = '0;
    found  = 1'b0;
    for (int i = 0; i < NUM_WIN; i++) begin
      if (hit[i] && !found) begin
        winner[i] = 1'b1;
        found     = 1'b1;
      end
    end
    winner_locked = |(winner & lock);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q      <= '0;
      miss_q     <= 1'b0;
      lock_err_q <= 1'b0;
    end else begin
      sel_q      <= '0;
      miss_q     <= 1'b0;
      lock_err_q <= 1'b0;
      if (req_valid) begin
        if (catch_all) begin
          sel_q <= NUM_WIN'(1);
        end else if (!found) begin
          miss_q <= 1'b1;
        end else if (req_write && winner_locked) begin
          lock_err_q <= 1'b1;
        end else begin
          sel_q <= winner;
        end
      end
    end
  end
endmodule

// File: rtl/cs_window_decoder.sv
module cs_window_decoder #(
  parameter int unsigned NUM_WIN = 6,
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned TAG_W   = 16,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned CFG_AW  = 7
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_we,
  input  logic [CFG_AW-1:0]  cfg_addr,
  input  logic [DATA_W-1:0]  cfg_wdata,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic [ADDR_W-1:0]  req_addr,
  output logic [NUM_WIN-1:0] cs_sel,
  output logic               nohit_err,
  output logic               wp_err
);
  localparam int unsigned ADDR_TAG_LSB = ADDR_W - TAG_W;

  logic [NUM_WIN-1:0][TAG_W-1:0] win_tag;
  logic [NUM_WIN-1:0][TAG_W-1:0] win_mask;
  logic [NUM_WIN-1:0]            win_en;
  logic [NUM_WIN-1:0]            win_lock;
  logic [NUM_WIN-1:0]            win_hit;
  logic [TAG_W-1:0]              addr_tag;

  assign addr_tag = req_addr[ADDR_TAG_LSB +: TAG_W];

  cs_cfg_regs #(
    .NUM_WIN(NUM_WIN), .TAG_W(TAG_W), .DATA_W(DATA_W), .CFG_AW(CFG_AW)
  ) u_regs (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .win_tag(win_tag), .win_mask(win_mask),
    .win_en(win_en), .win_lock(win_lock)
  );

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    cs_window_match #(.TAG_W(TAG_W)) u_match (
      .addr_tag(addr_tag), .tag(win_tag[w]), .dont_care(win_mask[w]),
      .enable(win_en[w]), .hit(win_hit[w])
    );
  end

  cs_select_arb #(.NUM_WIN(NUM_WIN)) u_arb (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .catch_all(!win_en[0]), .hit(win_hit), .lock(win_lock),
    .sel_q(cs_sel), .miss_q(nohit_err), .lock_err_q(wp_err)
  );
endmodule

// File: rtl/cs_dec_checker.sv
module cs_dec_checker #(
  parameter int unsigned NUM_WIN = 6
) (
  input logic               clk,
  input logic               rst,
  input logic               req_valid,
  input logic               req_write,
  input logic [NUM_WIN-1:0] cs_sel,
  input logic               nohit_err,
  input logic               wp_err,
  input logic               win0_en
);
  p_onehot_r3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(cs_sel));

  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (cs_sel == '0 && !nohit_err && !wp_err));

  p_single_outcome_r8: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> ($countones({(cs_sel != '0), nohit_err, wp_err}) == 1));

  p_catch_all_r5: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !win0_en) |=> (cs_sel == NUM_WIN'(1)));

  p_read_no_lock_r6: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write) |=> !wp_err);

  p_no_miss_catch_all_r7: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !win0_en) |=> !nohit_err);
endmodule

bind cs_window_decoder cs_dec_checker #(.NUM_WIN(NUM_WIN)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
  .cs_sel(cs_sel), .nohit_err(nohit_err), .wp_err(wp_err),
  .win0_en(win_en[0])
);

// File: tb/cs_window_decoder_test.sv
`timescale 1ns/1ps
module cs_window_decoder_test;
  localparam int NW = 6;

  logic        clk = 1'b0;
  logic        rst;
  logic        cfg_we;
  logic [6:0]  cfg_addr;
  logic [31:0] cfg_wdata;
  logic        req_valid, req_write;
  logic [31:0] req_addr;
  logic [NW-1:0] cs_sel;
  logic        nohit_err, wp_err;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [15:0] m_tag  [NW];
  logic [15:0] m_mask [NW];
  bit          m_en   [NW];
  bit          m_lock [NW];

  always #10 clk = ~clk;

  cs_window_decoder uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .cs_sel(cs_sel), .nohit_err(nohit_err), .wp_err(wp_err)
  );

  // model of R9 register map
  function automatic void model_write(input logic [6:0] a, input logic [31:0] d);
    int idx = int'(a) / 12;
    int off = int'(a) % 12;
    if (idx < NW) begin
      if (off == 0) m_tag[idx] = d[31:16];
      else if (off == 4) begin
        m_mask[idx] = d[31:16];
        m_en[idx]   = d[0];
        m_lock[idx] = d[8];
      end
    end
  endfunction

  // expected outcome per R2..R7
  function automatic logic [NW+1:0] model_decode(input bit v, input bit wr,
                                                 input logic [31:0] ad);
    logic [NW-1:0] s = '0;
    bit miss = 0, lerr = 0;
    int win = -1;
    if (v) begin
      if (!m_en[0]) s[0] = 1'b1;
      else begin
        for (int i = NW - 1; i >= 0; i--)
          if (m_en[i] && (((ad[31:16] ^ m_tag[i]) & ~m_mask[i]) == 16'h0)) win = i;
        if (win < 0) miss = 1;
        else if (wr && m_lock[win]) lerr = 1;
        else s[win] = 1'b1;
      end
    end
    return {s, miss, lerr};
  endfunction

  task automatic step(input bit cw, input logic [6:0] ca, input logic [31:0] cd,
                      input bit rv, input bit rw, input logic [31:0] ra,
                      input string req);
    logic [NW+1:0] exp, got;
    cfg_we = cw; cfg_addr = ca; cfg_wdata = cd;
    req_valid = rv; req_write = rw; req_addr = ra;
    exp = model_decode(rv, rw, ra);
    @(posedge clk);
    if (cw) model_write(ca, cd);
    @(negedge clk);
    cfg_we = 0; req_valid = 0;
    got = {cs_sel, nohit_err, wp_err};
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s addr=%h wr=%0d: got sel=%b miss=%b lock=%b expected sel=%b miss=%b lock=%b",
               req, ra, rw, got[NW+1:2], got[1], got[0], exp[NW+1:2], exp[1], exp[0]);
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'd4242));
    for (int i = 0; i < NW; i++) begin
      m_tag[i] = '0; m_mask[i] = '0; m_en[i] = 0; m_lock[i] = 0;
    end
    rst = 1; cfg_we = 0; cfg_addr = '0; cfg_wdata = '0;
    req_valid = 0; req_write = 0; req_addr = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    checks++;
    if (cs_sel !== '0 || nohit_err !== 0 || wp_err !== 0) begin
      failures++;
      $display("FAIL R1 reset outputs got %b%b%b expected all zero", cs_sel, nohit_err, wp_err);
    end
    step(0, 0, 0, 1, 0, 32'h1234_0000, "R1 catch-all after reset");

    // R5: catch-all while window 0 disabled
    step(1, 7'd24, 32'h2000_0000, 0, 0, 0, "R8 idle");
    step(1, 7'd28, 32'h00FF_0001, 1, 0, 32'h2000_0000, "R5 read ignores window 2");
    step(1, 7'd12, 32'h2000_0000, 1, 1, 32'h2010_0000, "R5 write");
    step(1, 7'd16, 32'h000F_0101, 0, 0, 0, "R8 idle");
    step(1, 7'd4,  32'h00FF_0100, 1, 1, 32'h2005_0000, "R5 lock disregarded");
    step(1, 7'd0,  32'h1000_0000, 1, 1, 32'h1000_0000, "R5 window0 lock disregarded");
    step(1, 7'd4,  32'h00FF_0001, 0, 0, 0, "R8 idle");

    // programmed decoding
    step(0, 0, 0, 1, 0, 32'h10AB_0000, "R2 masked match window 0");
    step(0, 0, 0, 1, 0, 32'h11AB_0000, "R7 miss");
    step(0, 0, 0, 1, 0, 32'h2005_1234, "R3 lowest window wins");
    step(0, 0, 0, 1, 1, 32'h2005_0000, "R6 locked write");
    step(0, 0, 0, 1, 0, 32'h2055_0000, "R2 window 2 match");
    step(0, 0, 0, 1, 1, 32'h2055_0000, "R6 non-winner lock ignored");
    step(1, 7'd36, 32'h3000_0000, 1, 0, 32'h3000_0000, "R4 disabled window");
    step(1, 7'd44, 32'hFFFF_FFFF, 1, 0, 32'h3000_0000, "R9 timing word no effect");
    step(0, 0, 0, 1, 0, 32'h3000_0000, "R9 timing word no effect");
    step(1, 7'd76, 32'hFFFF_FFFF, 1, 0, 32'h1000_0000, "R9 unmapped write");
    step(0, 0, 0, 1, 0, 32'h10FF_0000, "R9 unmapped write no effect");
    step(0, 0, 0, 1, 0, 32'hFFFF_0000, "R9 unmapped write no effect");
    step(1, 7'd40, 32'h0000_0001, 0, 0, 0, "R8 idle");
    step(0, 0, 0, 1, 0, 32'h3000_0000, "R4 enabled window 3");
    step(1, 7'd36, 32'h4000_0000, 1, 0, 32'h3000_0000, "R10 old tag used");
    step(0, 0, 0, 1, 0, 32'h3000_0000, "R10 old tag gone");
    step(0, 0, 0, 1, 1, 32'h4000_0000, "R10 new tag active");
    step(0, 0, 0, 0, 0, 32'h1000_0000, "R8 no request");

    // constrained random mix
    for (int n = 0; n < 3000; n++) begin
      bit cw = ($urandom_range(0, 99) < 15);
      int w = $urandom_range(0, NW - 1);
      logic [6:0] ca;
      logic [31:0] cd = $urandom;
      logic [31:0] ra = $urandom;
      int r = $urandom_range(0, 9);
      if (r < 8) ca = 7'(w * 12 + 4 * $urandom_range(0, 2));
      else ca = 7'($urandom_range(72, 127));
      if ($urandom_range(0, 3) != 0) begin
        int t = $urandom_range(0, NW - 1);
        ra[31:16] = m_tag[t] ^ (16'($urandom) & m_mask[t]);
      end
      step(cw, ca, cd, ($urandom_range(0, 9) != 0), $urandom_range(0, 1),
           ra, "R2 R3 R6 R7 R10 random");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule